// File: doc/BRIEF.md
# ADPCM Sample Playback Controller

This block feeds a single-channel ADPCM decoder from a shared sample memory. A CPU loads the memory one byte at a time through a byte port. Playback reads the same storage as 4-bit nibbles. Sample streams can therefore start on either half of any byte. The CPU sets three things through a small register file: a nibble start address, a length counted in bytes, and a 4-bit clock-divider code. It then writes a go bit.

During playback the controller releases the decoder from reset. Each time the decoder raises its per-sample strobe, the controller moves to the next nibble and places it on the 4-bit data output. After two nibbles per programmed byte, playback ends: a done flag is raised and the decoder is held in reset again.

The decoder's clock is a one-cycle enable pulse on the system clock. It is derived by dividing an input enable (nominally about 1.54 MHz) by 16 minus the divider code. A divider change only takes effect at the end of the divided period already in progress.

Top module: `adpcm_play_ctrl`

## Requirements
- R1: After reset, `dec_rst` is 1, the control register reads 0 (busy bit 0, done bit 1 both clear), the divider register reads 0, and `dec_xt` pulses once every 16 `clk_en` ticks.
- R2: A byte written through the CPU memory port at an address is returned on `cpu_mem_rdata` one clock after that address is presented for reading.
- R3: Register select 0/1 hold the low/high byte of the nibble start address, 2/3 the low/high byte of the byte length, 4 the divider code and 5 the control register. Bits above the implemented widths read back as 0, so with default parameters the high start and length bytes keep only bits 2:0 and the divider register keeps only bits 3:0.
- R4: With divider code n (0..15), `dec_xt` pulses once every 16-n ticks of `clk_en`. Every pulse coincides with a `clk_en` tick. For n=15, `dec_xt` equals `clk_en`.
- R5: A divider write made mid-period leaves the period in progress at its old length; the new ratio applies from the next period on.
- R6: Writing 1 to control bit 0 with a nonzero length starts playback. Busy (control bit 0) then reads 1, done (bit 1) reads 0, `dec_rst` is 0, and the nibble at the start address is on `dec_data` within two clocks.
- R7: The nibble at an even nibble address is bits 3:0 of byte address/2, and the nibble at an odd address is bits 7:4. Each rising edge of `dec_vck` advances the nibble address by one, and the new nibble is on `dec_data` two clocks after the edge is sampled.
- R8: After 2×length strobe edges, busy clears, done sets and `dec_rst` returns to 1. Further strobe edges then change neither the status nor `dec_data`.
- R9: Starting with length 0 sets done without ever setting busy, and `dec_rst` stays 1.
- R10: The nibble address wraps from the top of memory to nibble 0.
- R11: A strobe held high for several clocks advances playback only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_mem_we | input | 1 | CPU memory byte write enable |
| cpu_mem_addr | input | ADDR_W | CPU byte address (write and read) |
| cpu_mem_wdata | input | 8 | CPU write byte |
| cpu_mem_rdata | output | 8 | CPU read byte, one clock after address |
| cpu_reg_we | input | 1 | Register write enable |
| cpu_reg_sel | input | 3 | Register select |
| cpu_reg_wdata | input | 8 | Register write byte |
| cpu_reg_rdata | output | 8 | Register read byte (combinational) |
| clk_en | input | 1 | Undivided decoder-clock enable |
| dec_xt | output | 1 | Divided decoder clock enable pulse |
| dec_vck | input | 1 | Decoder per-sample strobe |
| dec_rst | output | 1 | Decoder reset, high when not playing |
| dec_data | output | 4 | Current sample nibble |

## Verification
The hardest situation to reach is a divider write that lands in the middle of a divided period. From the ports it is visible only as the length of the period that straddles the write. The stimulus first locks onto a `dec_xt` pulse, waits a few clocks, and writes the new code. It then measures that interval against the old ratio and the next one against the new ratio. The nibble wrap at the top of memory is reached by programming start addresses in the last few nibbles, with lengths long enough to cross nibble 0.

// File: rtl/adpcm_play_pkg.sv
package adpcm_play_pkg;

  typedef enum logic [2:0] {
    REG_START_LO = 3'd0,
    REG_START_HI = 3'd1,
    REG_LEN_LO   = 3'd2,
    REG_LEN_HI   = 3'd3,
    REG_DIV      = 3'd4,
    REG_CTRL     = 3'd5
  } reg_sel_e;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_BUSY_BIT = 0;
  localparam int CTRL_DONE_BIT = 1;

endpackage

// File: rtl/adpcm_sample_ram.sv
module adpcm_sample_ram #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [7:0]        a_wdata,
  output logic [7:0]        a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [7:0]        b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // port A: CPU byte access, port B: playback read
  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_addr] <= a_wdata;
    end
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/adpcm_xt_divider.sv
module adpcm_xt_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] div_code,
  output logic             xt_pulse
);
  localparam int DIV_MAX = 1 << DIV_W;
  localparam int RATIO_W = DIV_W + 1;

  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               at_end;

  assign at_end   = (cnt_q == ratio_q - RATIO_W'(1));
  assign xt_pulse = clk_en & at_end;

  always_comb begin
    ratio_d = ratio_q;
    cnt_d   = cnt_q;
    if (clk_en) begin
      if (at_end) begin
        cnt_d   = '0;
        ratio_d = RATIO_W'(DIV_MAX) - RATIO_W'(div_code);
      end else begin
        cnt_d = cnt_q + RATIO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_W'(DIV_MAX);
      cnt_q   <= '0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
    end
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  // R5
  ratio_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && at_end) |=> $stable(ratio_q));

endmodule

// File: rtl/adpcm_nibble_seq.sv
module adpcm_nibble_seq #(
  parameter int NIB_W = 11,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NIB_W-1:0] start_addr,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic             vck,
  output logic [NIB_W-2:0] byte_addr,
  output logic             nib_hi,
  output logic             busy,
  output logic             done
);
  localparam int REM_W = LEN_W + 1;

  logic [NIB_W-1:0] nib_q, nib_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic             busy_d, done_d;
  logic             vck_q;
  logic             vck_rise;

  assign vck_rise  = vck & ~vck_q & busy;
  assign byte_addr = nib_q[NIB_W-1:1];

  always_comb begin
    nib_d  = nib_q;
    rem_d  = rem_q;
    busy_d = busy;
    done_d = done;
    if (go) begin
      nib_d = start_addr;
      rem_d = {len_bytes, 1'b0};
      if (len_bytes == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        done_d = 1'b0;
      end
    end else if (vck_rise) begin
      nib_d = nib_q + NIB_W'(1);
      rem_d = rem_q - REM_W'(1);
      if (rem_q == REM_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q  <= '0;
      rem_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      vck_q  <= 1'b0;
      nib_hi <= 1'b0;
    end else begin
      nib_q  <= nib_d;
      rem_q  <= rem_d;
      busy   <= busy_d;
      done   <= done_d;
      vck_q  <= vck;
      nib_hi <= nib_q[0];
    end
  end

  // R6
  go_starts_or_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy || done));

  // R7
  advance_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vck_rise && !go) |=> (nib_q == NIB_W'($past(nib_q) + NIB_W'(1))));

  // R8
  end_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && len_bytes == '0) |=> (done && !busy));

  // R11
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go && $past(busy)) |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - REM_W'(1)));

endmodule

// File: rtl/adpcm_play_regs.sv
module adpcm_play_regs
  import adpcm_play_pkg::*;
#(
  parameter int NIB_W = 11,
  parameter int LEN_W = 11,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [7:0]       wdata,
  input  logic             busy,
  input  logic             done,
  output logic [7:0]       rdata,
  output logic [NIB_W-1:0] start_addr,
  output logic [LEN_W-1:0] len_bytes,
  output logic [DIV_W-1:0] div_code,
  output logic             go
);
  logic [NIB_W-1:0] start_d;
  logic [LEN_W-1:0] len_d;
  logic [DIV_W-1:0] div_d;
  logic [15:0]      start_w, len_w;

  assign start_w = 16'(start_addr);
  assign len_w   = 16'(len_bytes);
  assign go      = we && (sel == REG_CTRL) && wdata[CTRL_GO_BIT];

  always_comb begin
    start_d = start_addr;
    len_d   = len_bytes;
    div_d   = div_code;
    if (we) begin
      case (sel)
        REG_START_LO: start_d = NIB_W'({start_w[15:8], wdata});
        REG_START_HI: start_d = NIB_W'({wdata, start_w[7:0]});
        REG_LEN_LO:   len_d   = LEN_W'({len_w[15:8], wdata});
        REG_LEN_HI:   len_d   = LEN_W'({wdata, len_w[7:0]});
        REG_DIV:      div_d   = wdata[DIV_W-1:0];
        default:      ;
      endcase
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (sel)
      REG_START_LO: rdata = start_w[7:0];
      REG_START_HI: rdata = start_w[15:8];
      REG_LEN_LO:   rdata = len_w[7:0];
      REG_LEN_HI:   rdata = len_w[15:8];
      REG_DIV:      rdata = 8'(div_code);
      REG_CTRL: begin
        rdata[CTRL_BUSY_BIT] = busy;
        rdata[CTRL_DONE_BIT] = done;
      end
      default:      rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      len_bytes  <= '0;
      div_code   <= '0;
    end else begin
      start_addr <= start_d;
      len_bytes  <= len_d;
      div_code   <= div_d;
    end
  end

endmodule

// File: rtl/adpcm_play_ctrl.sv
module adpcm_play_ctrl #(
  parameter int ADDR_W = 10,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_mem_we,
  input  logic [ADDR_W-1:0] cpu_mem_addr,
  input  logic [7:0]        cpu_mem_wdata,
  output logic [7:0]        cpu_mem_rdata,
  input  logic              cpu_reg_we,
  input  logic [2:0]        cpu_reg_sel,
  input  logic [7:0]        cpu_reg_wdata,
  output logic [7:0]        cpu_reg_rdata,
  input  logic              clk_en,
  output logic              dec_xt,
  input  logic              dec_vck,
  output logic              dec_rst,
  output logic [3:0]        dec_data
);
  localparam int NIB_W = ADDR_W + 1;
  localparam int LEN_W = ADDR_W + 1;

  logic              rst_s1, rst_s2;
  logic [NIB_W-1:0]  start_addr;
  logic [LEN_W-1:0]  len_bytes;
  logic [DIV_W-1:0]  div_code;
  logic              go, busy, done, nib_hi;
  logic [ADDR_W-1:0] play_addr;
  logic [7:0]        play_byte;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  adpcm_play_regs #(.NIB_W(NIB_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_s2), .we(cpu_reg_we), .sel(cpu_reg_sel),
    .wdata(cpu_reg_wdata), .busy(busy), .done(done), .rdata(cpu_reg_rdata),
    .start_addr(start_addr), .len_bytes(len_bytes), .div_code(div_code), .go(go)
  );

  adpcm_xt_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_s2), .clk_en(clk_en), .div_code(div_code),
    .xt_pulse(dec_xt)
  );

  adpcm_nibble_seq #(.NIB_W(NIB_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_s2), .go(go), .start_addr(start_addr),
    .len_bytes(len_bytes), .vck(dec_vck), .byte_addr(play_addr),
    .nib_hi(nib_hi), .busy(busy), .done(done)
  );

  adpcm_sample_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .a_we(cpu_mem_we), .a_addr(cpu_mem_addr), .a_wdata(cpu_mem_wdata),
    .a_rdata(cpu_mem_rdata), .b_addr(play_addr), .b_rdata(play_byte)
  );

  assign dec_rst  = ~busy;
  assign dec_data = nib_hi ? play_byte[7:4] : play_byte[3:0];

endmodule

// File: tb/adpcm_play_ctrl_tb.sv
module adpcm_play_ctrl_tb;
  localparam int ADDR_W = 10;
  localparam int NIBS   = 1 << (ADDR_W + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_mem_we = 1'b0;
  logic [ADDR_W-1:0] cpu_mem_addr = '0;
  logic [7:0] cpu_mem_wdata = '0;
  logic [7:0] cpu_mem_rdata;
  logic       cpu_reg_we = 1'b0;
  logic [2:0] cpu_reg_sel = '0;
  logic [7:0] cpu_reg_wdata = '0;
  logic [7:0] cpu_reg_rdata;
  logic       clk_en = 1'b0;
  logic       dec_xt;
  logic       dec_vck = 1'b0;
  logic       dec_rst;
  logic [3:0] dec_data;

  int total = 0;
  int bad = 0;
  int en_period = 1;
  int en_phase = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adpcm_play_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_mem_we(cpu_mem_we), .cpu_mem_addr(cpu_mem_addr),
    .cpu_mem_wdata(cpu_mem_wdata), .cpu_mem_rdata(cpu_mem_rdata),
    .cpu_reg_we(cpu_reg_we), .cpu_reg_sel(cpu_reg_sel), .cpu_reg_wdata(cpu_reg_wdata),
    .cpu_reg_rdata(cpu_reg_rdata), .clk_en(clk_en), .dec_xt(dec_xt),
    .dec_vck(dec_vck), .dec_rst(dec_rst), .dec_data(dec_data)
  );

  // enable generator: changes shortly after the rising edge
  always @(posedge clk) begin
    #2;
    clk_en <= (en_phase == 0);
    en_phase <= (en_phase + 1 >= en_period) ? 0 : en_phase + 1;
  end

  function automatic int pat(int a);
    return (a * 37 + 11) & 255;
  endfunction

  function automatic int nib_at(int p);
    int q = p % NIBS;
    return (q & 1) ? (pat(q >> 1) >> 4) : (pat(q >> 1) & 15);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(int sel, int val);
    @(negedge clk);
    cpu_reg_we = 1'b1; cpu_reg_sel = 3'(sel); cpu_reg_wdata = 8'(val);
    @(negedge clk);
    cpu_reg_we = 1'b0;
  endtask

  task automatic reg_rd(int sel, output int val);
    cpu_reg_sel = 3'(sel);
    #1;
    val = int'(cpu_reg_rdata);
  endtask

  task automatic interval(output int n);
    n = 0;
    while (dec_xt !== 1'b1) @(negedge clk);
    do begin
      @(negedge clk);
      n++;
    end while (dec_xt !== 1'b1 && n < 1000);
  endtask

  task automatic strobe();
    dec_vck = 1'b1;
    repeat (2) @(negedge clk);
    dec_vck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic play(int start, int len);
    int v;
    reg_wr(0, start & 255);
    reg_wr(1, start >> 8);
    reg_wr(2, len & 255);
    reg_wr(3, len >> 8);
    reg_wr(5, 1);
    repeat (2) @(negedge clk);
    reg_rd(5, v);
    chk("R6 status busy", v, 1);
    chk("R6 dec_rst low", int'(dec_rst), 0);
    for (int i = 0; i < 2 * len; i++) begin
      if ((start + i) >= NIBS) chk("R10 wrapped nibble", int'(dec_data), nib_at(start + i));
      else chk("R7 nibble", int'(dec_data), nib_at(start + i));
      if (i == 0) begin
        // R11: long strobe counts once
        dec_vck = 1'b1;
        repeat (5) @(negedge clk);
        dec_vck = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        strobe();
      end
    end
    reg_rd(5, v);
    chk("R8 done status", v, 2);
    chk("R8 dec_rst high", int'(dec_rst), 1);
    strobe();
    reg_rd(5, v);
    chk("R8 status after extra strobe", v, 2);
    chk("R8 data after extra strobe", int'(dec_data), nib_at(start + 2 * len));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n;
    int starts[10] = '{0, 1, 2, 3, 100, 101, NIBS-4, NIBS-3, NIBS-2, NIBS-1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 dec_rst", int'(dec_rst), 1);
    reg_rd(5, v); chk("R1 ctrl", v, 0);
    reg_rd(4, v); chk("R1 div", v, 0);
    interval(n); interval(n); chk("R1 period 16", n, 16);

    // R2 memory fill and readback
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      @(negedge clk);
      cpu_mem_we = 1'b1; cpu_mem_addr = ADDR_W'(a); cpu_mem_wdata = 8'(pat(a));
    end
    @(negedge clk); cpu_mem_we = 1'b0;
    for (int a = 0; a < (1 << ADDR_W); a += 7) begin
      cpu_mem_addr = ADDR_W'(a);
      @(negedge clk);
      chk("R2 readback", int'(cpu_mem_rdata), pat(a));
    end

    // R3 register readback and masking
    reg_wr(0, 8'hA5); reg_rd(0, v); chk("R3 start lo", v, 8'hA5);
    reg_wr(1, 8'hFF); reg_rd(1, v); chk("R3 start hi masked", v, 7);
    reg_wr(2, 8'h3C); reg_rd(2, v); chk("R3 len lo", v, 8'h3C);
    reg_wr(3, 8'hFF); reg_rd(3, v); chk("R3 len hi masked", v, 7);
    reg_wr(4, 8'hF3); reg_rd(4, v); chk("R3 div masked", v, 3);

    // R4 divider sweep, enable every clock
    en_period = 1;
    for (int d = 0; d < 16; d++) begin
      reg_wr(4, d);
      interval(n); interval(n);
      chk("R4 period", n, 16 - d);
    end
    // R4 sparse enable
    en_period = 3;
    for (int d = 0; d < 16; d += 5) begin
      reg_wr(4, d);
      interval(n); interval(n);
      chk("R4 sparse period", n, 3 * (16 - d));
    end
    en_period = 1;

    // R5 mid-period change
    reg_wr(4, 6);
    interval(n); interval(n);
    chk("R5 old period", n, 10);
    repeat (3) @(negedge clk);
    cpu_reg_we = 1'b1; cpu_reg_sel = 3'd4; cpu_reg_wdata = 8'd12;
    @(negedge clk); cpu_reg_we = 1'b0;
    n = 4;
    while (dec_xt !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk("R5 straddling period", n, 10);
    n = 0;
    do begin @(negedge clk); n++; end while (dec_xt !== 1'b1 && n < 1000);
    chk("R5 new period", n, 4);

    // R9 zero length
    reg_wr(2, 0); reg_wr(3, 0); reg_wr(5, 1);
    repeat (2) @(negedge clk);
    reg_rd(5, v); chk("R9 done only", v, 2);
    chk("R9 dec_rst", int'(dec_rst), 1);

    // R6 R7 R8 R10 R11 playback sweep
    for (int s = 0; s < 10; s++)
      for (int l = 1; l <= 3; l++)
        play(starts[s], l);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule